// File: doc/BRIEF.md
# Boot Width Latch and Address Remap Decoder

This block sits between a processor bus and the regions behind it. While the external reset input is low it samples a boot-select pin every clock. When reset is released it keeps the last sampled level as the data width of the external boot memory on chip select 0: 8 bits or 16 bits. It then decodes every bus access into one target. The targets are chip select 0 boot memory, internal SRAM, internal peripherals, or one of eight external chip-select windows. When no target claims an address in the external region, the block raises an abort in the same cycle as the access.

Address zero moves when software writes a one-way remap command. Before remap, the low 4 MB region holds boot memory, and SRAM is reachable only through a fixed alias at 0x0030_0000. After remap, SRAM sits at address zero, so the exception vectors can be rewritten. Chip selects 1 to 7 are also decoded only after remap. The remap state returns to zero only when the external reset is low or the internal reset input is high.

Top module: `boot_remap_ctrl`

## Requirements
- R1: `boot_w8` equals the `boot_sel` level sampled at the last rising clock edge that saw `rst_n` low. A value of 1 means 8-bit boot memory and 0 means 16-bit. Changes on `boot_sel` while `rst_n` is high leave `boot_w8` unchanged.
- R2: Before remap, a strobed address in the low region selects an output as follows. The low region is bits [31:22] equal to 0. If bits [21:20] are 0, 1 or 2, `sel_cs[0]` is asserted. If bits [21:20] are 3, which is the SRAM alias at 0x0030_0000, `sel_sram` is asserted.
- R3: A configuration write to offset 0 with data bit 0 set to 1 sets remap, and the new state takes effect from the next cycle. After remap, a low-region address with bits [21:20] equal to 0 asserts `sel_sram`. Any other low-region address selects nothing and does not abort.
- R4: Writing 0 to offset 0 has no effect on remap. Remap is cleared only while `rst_n` is low or `int_rst` is high. `int_rst` leaves the window registers unchanged.
- R5: Each window n (n = 0 to 7) has a register at offset 8+n. Bits [11:0] of that register are compared with address bits [31:20], and bit 31 enables the window. An enabled window matches a strobed external-region address with the same bits [31:20]. Windows 1 to 7 match only after remap, while window 0 matches at any time. When several windows match, the lowest index drives its `sel_cs` bit.
- R6: An address with bits [31:22] all ones (0xFFC0_0000 and above) asserts `sel_periph` and never aborts.
- R7: `abort` is asserted in the same cycle as the strobe for an external-region address that no window matches. The external region runs from 0x0040_0000 up to but not including 0xFFC0_0000.
- R8: Offset 0 of `cfg_rdata` reads the remap state in bit 0. Offset 8+n returns the window's enable in bit 31 and its base in bits [11:0]. All other bits and offsets read 0.
- R9: With `strobe` low, all select outputs and `abort` are 0. At any time, at most one of `sel_cs`, `sel_sram`, `sel_periph` and `abort` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, sampled synchronously |
| int_rst | input | 1 | Internal reset that clears remap only |
| boot_sel | input | 1 | Boot width select pin (1 = 8-bit, 0 = 16-bit) |
| strobe | input | 1 | Bus access valid |
| addr | input | 32 | Bus byte address |
| cfg_wr | input | 1 | Configuration register write |
| cfg_addr | input | 4 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| boot_w8 | output | 1 | Latched boot memory width, 1 = 8-bit |
| sel_cs | output | 8 | External chip selects 0 to 7 |
| sel_sram | output | 1 | Internal SRAM select |
| sel_periph | output | 1 | Internal peripheral select |
| abort | output | 1 | Undefined external address |

## Verification
The decode outputs, `abort` and `cfg_rdata` are combinational, so they are due in the same cycle as the address or offset. The bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. A configuration write is presented for one cycle and changes the decode from the following falling edge, and every check after a write is made there. The boot width is compared a few cycles after reset release. The bench first holds the opposite pin level for most of the reset window and switches to the target level only for the last sampling edge, then toggles the pin after release to show that it is ignored.

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl #(
  parameter int NCS     = 8,
  parameter int AW      = 32,
  parameter int WIN_LSB = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      int_rst,
  input  logic                      boot_sel,
  input  logic                      strobe,
  input  logic [AW-1:0]             addr,
  input  logic                      cfg_wr,
  input  logic [$clog2(NCS):0]      cfg_addr,
  input  logic [31:0]               cfg_wdata,
  output logic [31:0]               cfg_rdata,
  output logic                      boot_w8,
  output logic [NCS-1:0]            sel_cs,
  output logic                      sel_sram,
  output logic                      sel_periph,
  output logic                      abort
);
  localparam int IW     = $clog2(NCS);
  localparam int BW     = AW - WIN_LSB;
  localparam int RGN_LSB = WIN_LSB + 2;

  logic              remap_q;
  logic [BW-1:0]     win_base [NCS];
  logic [NCS-1:0]    win_en;
  logic [NCS-1:0]    hit, pick;
  logic              low_rgn, hi_rgn, ext_rgn, boot_hit, unused_bits;

  always_ff @(posedge clk)
    if (!rst_n) boot_w8 <= boot_sel;

  always_ff @(posedge clk)
    if (!rst_n || int_rst)                            remap_q <= 1'b0;
    else if (cfg_wr && cfg_addr == '0 && cfg_wdata[0]) remap_q <= 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) begin
      win_en <= '0;
      for (int n = 0; n < NCS; n++) win_base[n] <= '0;
    end else if (cfg_wr && cfg_addr[IW]) begin
      win_en[cfg_addr[IW-1:0]]   <= cfg_wdata[31];
      win_base[cfg_addr[IW-1:0]] <= cfg_wdata[BW-1:0];
    end

  assign low_rgn  = addr[AW-1:RGN_LSB] == '0;
  assign hi_rgn   = &addr[AW-1:RGN_LSB];
  assign ext_rgn  = !low_rgn && !hi_rgn;
  assign boot_hit = low_rgn && !remap_q && addr[RGN_LSB-1:WIN_LSB] != 2'b11;

  for (genvar g = 0; g < NCS; g++) begin : g_win
    assign hit[g] = win_en[g] && ext_rgn && addr[AW-1:WIN_LSB] == win_base[g]
                    && (g == 0 || remap_q);
  end

  always_comb begin
    pick = '0;
    for (int n = NCS - 1; n >= 0; n--)
      if (hit[n]) begin
        pick = '0;
        pick[n] = 1'b1;
      end
  end

  assign sel_cs     = strobe ? (pick | {{(NCS-1){1'b0}}, boot_hit}) : '0;
  assign sel_sram   = strobe && low_rgn &&
                      (remap_q ? addr[RGN_LSB-1:WIN_LSB] == 2'b00
                               : addr[RGN_LSB-1:WIN_LSB] == 2'b11);
  assign sel_periph = strobe && hi_rgn;
  assign abort      = strobe && ext_rgn && hit == '0;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == '0)
      cfg_rdata[0] = remap_q;
    else if (cfg_addr[IW]) begin
      cfg_rdata[31]     = win_en[cfg_addr[IW-1:0]];
      cfg_rdata[BW-1:0] = win_base[cfg_addr[IW-1:0]];
    end
  end

  assign unused_bits = ^{cfg_wdata[30:BW], addr[WIN_LSB-1:0]};

  // R1
  boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(boot_w8));
  // R4
  remap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remap_q && !int_rst |=> remap_q);
  // R5
  late_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_q |-> sel_cs[NCS-1:1] == '0);
  // R6
  periph_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_periph |-> !abort);
  // R7
  abort_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> strobe && addr[AW-1:RGN_LSB] != '0 && !(&addr[AW-1:RGN_LSB]));
  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|sel_cs, sel_sram, sel_periph, abort}));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> sel_cs == '0 && !sel_sram && !sel_periph && !abort);
endmodule

// File: tb/boot_remap_ctrl_tb_top.sv
module boot_remap_ctrl_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, int_rst = 1'b0, boot_sel = 1'b0, strobe = 1'b0;
  logic [31:0] addr = '0, cfg_wdata = '0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_rdata;
  logic        boot_w8, sel_sram, sel_periph, abort;
  logic [7:0]  sel_cs;
  int checks = 0, failures = 0;
  bit done = 0;

  boot_remap_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .int_rst(int_rst), .boot_sel(boot_sel),
    .strobe(strobe), .addr(addr), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .boot_w8(boot_w8),
    .sel_cs(sel_cs), .sel_sram(sel_sram), .sel_periph(sel_periph), .abort(abort));

  wire [10:0] obs = {sel_cs, sel_sram, sel_periph, abort};
  localparam logic [10:0] NONE = 11'b0, SRAM = 11'b100, PER = 11'b010, ABT = 11'b001;
  function automatic logic [10:0] cs(input int n); return 11'(1) << (n + 3); endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic acc(input string tag, input logic [31:0] a, input logic [10:0] e);
    @(negedge clk); addr = a; strobe = 1'b1;
    #1 chk(tag, 32'(obs), 32'(e));
    @(negedge clk); strobe = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0; cfg_addr = '0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] e);
    @(negedge clk); cfg_addr = a;
    #1 chk(tag, cfg_rdata, e);
  endtask

  task automatic t_reset(input logic v);
    @(negedge clk); rst_n = 1'b0; boot_sel = ~v;
    repeat (11) @(negedge clk);
    boot_sel = v;
    @(negedge clk); rst_n = 1'b1; boot_sel = ~v;
    repeat (3) @(negedge clk);
    chk("R1 boot width after release", 32'(boot_w8), 32'(v));
    boot_sel = v; repeat (2) @(negedge clk); boot_sel = ~v; repeat (2) @(negedge clk);
    chk("R1 pin ignored after release", 32'(boot_w8), 32'(v));
    rd("R8 remap reads 0 after reset", 4'd0, 32'h0);
    #1 chk("R9 idle outputs", 32'(obs), 32'(NONE));
  endtask

  task automatic t_windows;
    wr(4'd8,  32'h8000_0100);
    wr(4'd9,  32'h8000_0200);
    wr(4'd10, 32'h8000_0200);
    wr(4'd11, 32'h0000_0300);
    rd("R8 window1 readback", 4'd9, 32'h8000_0200);
    rd("R8 window3 readback", 4'd11, 32'h0000_0300);
    rd("R8 unused offset", 4'd3, 32'h0);
  endtask

  task automatic t_preremap;
    acc("R2 boot at zero", 32'h0000_0000, cs(0));
    acc("R2 boot at 0x0020_0000", 32'h0020_0000, cs(0));
    acc("R2 sram alias", 32'h0030_0010, SRAM);
    acc("R5 cs0 window before remap", 32'h1000_0004, cs(0));
    acc("R5 cs1 blocked before remap", 32'h2000_0000, ABT);
    acc("R7 ext start abort", 32'h0040_0000, ABT);
    acc("R7 ext end abort", 32'hFFBF_FFFC, ABT);
    acc("R6 periph base", 32'hFFC0_0000, PER);
    acc("R6 periph top", 32'hFFFF_FFFC, PER);
  endtask

  task automatic t_remap;
    wr(4'd0, 32'h1);
    rd("R8 remap reads 1", 4'd0, 32'h1);
    acc("R3 sram at zero", 32'h0000_0000, SRAM);
    acc("R3 sram mirror", 32'h0000_1000, SRAM);
    acc("R3 old alias selects nothing", 32'h0030_0000, NONE);
    acc("R3 old boot range no target", 32'h0010_0000, NONE);
    acc("R5 overlap lowest index", 32'h2000_0000, cs(1));
    acc("R7 disabled window abort", 32'h3000_0000, ABT);
    acc("R5 cs0 window after remap", 32'h1000_0000, cs(0));
    wr(4'd11, 32'h8000_0300);
    acc("R5 cs3 enabled", 32'h300F_FFFC, cs(3));
  endtask

  task automatic t_clear;
    wr(4'd0, 32'h0);
    acc("R4 write zero ignored", 32'h0000_0000, SRAM);
    @(negedge clk); int_rst = 1'b1;
    @(negedge clk); int_rst = 1'b0;
    rd("R4 int_rst clears remap", 4'd0, 32'h0);
    acc("R4 boot back at zero", 32'h0000_0000, cs(0));
    rd("R4 windows kept over int_rst", 4'd8, 32'h8000_0100);
    acc("R9 idle strobe", 32'h0000_0000, cs(0));
  endtask

  initial begin
    t_reset(1'b1);
    t_windows;
    t_preremap;
    t_remap;
    t_clear;
    wr(4'd0, 32'h1);
    t_reset(1'b0);
    acc("R4 rst_n clears remap", 32'h0000_0000, cs(0));
    acc("R5 windows cleared by rst_n", 32'h1000_0000, ABT);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule